// File: doc/BRIEF.md
# Inter-Peer Doorbell Register Bank

This block is the 32-bit register window of a shared-memory device through which one peer signals another. Software sees four word registers inside a 256-byte window: an interrupt enable mask, an interrupt status word that clears itself when read, a read-only word holding the peer's own position, and a write-only doorbell. The window is reached through a simple valid/ready register port. The port accepts one access per cycle, and the read data returns one cycle after the access.

A doorbell write carries a destination peer and a vector number in one word. The block checks the destination against the configured number of peers, and it checks the vector against that peer's entry in a vector-count table. Only a doorbell that passes both checks produces a one-cycle notify strobe, which carries the peer and vector indices. A local event input loads the status register when the device runs without message-signalled interrupts. The level interrupt line is the OR of status AND mask. Two static flags can hold that line low.

Top module: `peer_doorbell_regs`

## Requirements
- R1: After reset the mask and status registers are zero, the interrupt line is low and no notify strobe is active.
- R2: A write to word offset 0 (byte 0x00) loads the mask with the full 32-bit write data, and a read of that offset returns it.
- R3: A write to word offset 1 (byte 0x04) loads status with the write data. While message-signalled mode is off and the pin-present flag is set, the interrupt line equals the OR of (status AND mask). The line follows every change to either register from the cycle after the access.
- R4: A read of word offset 1 returns the status value held before the access, and the same access clears status to zero.
- R5: A read of word offset 2 (byte 0x08) returns the 16-bit own-position input, zero-extended. Writes to that offset change nothing.
- R6: Reads of word offset 3 (byte 0x0C, the doorbell) and of every unmapped offset return zero. Writes to unmapped offsets change no register and raise no notify.
- R7: Address bits [1:0] are ignored, so only address bits [7:2] select a word.
- R8: On a doorbell write, bits [31:16] are the destination peer, bits [7:0] are the vector, and bits [15:8] are ignored. An accepted doorbell raises notify for exactly the one cycle after the write, with the peer and vector fields valid in that cycle.
- R9: A doorbell whose destination is not below the peer-count input, or not below the table size, produces no notify.
- R10: A doorbell whose vector is not below the destination's vector-count table entry (entry i sits at table bits [i*CNT_W +: CNT_W]) produces no notify.
- R11: A local event while message-signalled mode is off sets status to exactly 1. This takes precedence over a bus access to status in the same cycle, and a read in that cycle still returns the old value. In message-signalled mode the event is ignored.
- R12: While message-signalled mode is on or the pin-present flag is clear, the interrupt line stays low whatever status and mask hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Always high, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| own_id | input | 16 | This peer's own position |
| peer_count | input | 16 | Number of peers currently known |
| vec_cnt_tbl | input | NUM_PEERS*CNT_W | Registered vector count per peer, packed |
| msi_mode | input | 1 | Message-signalled mode flag |
| irq_pin_en | input | 1 | Interrupt pin present flag |
| local_event | input | 1 | Incoming event for this peer |
| irq | output | 1 | Level interrupt |
| ntf_valid | output | 1 | Single-cycle notify strobe |
| ntf_peer | output | 16 | Notified peer index |
| ntf_vec | output | 8 | Notified vector index |

## Verification
On every cycle the assertions check that a mask write lands, that a status read leaves zero behind, that an event forces status to 1, that notify never fires without a doorbell write before it or after an out-of-range destination, that the suppress flags hold the line low, and that address bits [1:0] do not affect a read of the own position. Only the bench scenarios can show read-back values across offsets, whether the vector bound is right for each table entry, how the interrupt line follows random sequences of mask and status changes, and the priority between a concurrent event and a read.

// File: rtl/db_pkg.sv
package db_pkg;
   localparam int WIN_AW = 8;
   localparam int DATA_W = 32;
   localparam int PEER_W = 16;
   localparam int VEC_W  = 8;
   localparam int IDX_W  = WIN_AW - 2;

   typedef enum logic [IDX_W-1:0] {
      W_MASK = 6'd0,
      W_STAT = 6'd1,
      W_POS  = 6'd2,
      W_BELL = 6'd3
   } word_e;
endpackage

// File: rtl/db_regfile.sv
module db_regfile
   import db_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              wr,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PEER_W-1:0] own_id,
   input  logic              msi_mode,
   input  logic              local_event,
   output logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] stat_q,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   logic              ev_set;
   logic [DATA_W-1:0] rd_mux;

   assign ev_set = local_event && !msi_mode;

   always_comb begin
      case (idx)
         W_MASK:  rd_mux = mask_q;
         W_STAT:  rd_mux = stat_q;
         W_POS:   rd_mux = {{(DATA_W-PEER_W){1'b0}}, own_id};
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q    <= '0;
         stat_q    <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= acc && !wr;
         if (acc && !wr)
            rsp_rdata <= rd_mux;
         if (acc && wr && idx == W_MASK)
            mask_q <= wdata;
         if (ev_set)
            stat_q <= {{(DATA_W-1){1'b0}}, 1'b1};
         else if (acc && wr && idx == W_STAT)
            stat_q <= wdata;
         else if (acc && !wr && idx == W_STAT)
            stat_q <= '0;
      end
   end

   a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && wr && idx == W_MASK) |=> (mask_q == $past(wdata)));

   a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !wr && idx == W_STAT && !ev_set) |=> (stat_q == '0));

   a_r11_event_sets_one: assert property (@(posedge clk) disable iff (!rst_n)
      (local_event && !msi_mode) |=> (stat_q == 32'd1));
endmodule

// File: rtl/db_bell_check.sv
module db_bell_check
   import db_pkg::*;
#(
   parameter int NUM_PEERS = 8,
   parameter int CNT_W     = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       fire,
   input  logic [PEER_W-1:0]          dest,
   input  logic [VEC_W-1:0]           vec,
   input  logic [PEER_W-1:0]          peer_count,
   input  logic [NUM_PEERS*CNT_W-1:0] vec_cnt_tbl,
   output logic                       ntf_valid,
   output logic [PEER_W-1:0]          ntf_peer,
   output logic [VEC_W-1:0]           ntf_vec
);
   localparam int PIDX_W = $clog2(NUM_PEERS);
   localparam int CMP_W  = (CNT_W > VEC_W) ? CNT_W : VEC_W;

   logic [CNT_W-1:0] cnt_a [NUM_PEERS];
   logic             dest_ok;
   logic [CNT_W-1:0] sel_cnt;
   logic             vec_ok;
   logic             pass;

   for (genvar g = 0; g < NUM_PEERS; g++) begin : g_tbl
      assign cnt_a[g] = vec_cnt_tbl[g*CNT_W +: CNT_W];
   end

   assign dest_ok = (dest < peer_count) &&
                    ({1'b0, dest} < (PEER_W+1)'(NUM_PEERS));
   assign sel_cnt = dest_ok ? cnt_a[dest[PIDX_W-1:0]] : '0;
   assign vec_ok  = CMP_W'(vec) < CMP_W'(sel_cnt);
   assign pass    = fire && dest_ok && vec_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ntf_valid <= 1'b0;
         ntf_peer  <= '0;
         ntf_vec   <= '0;
      end else begin
         ntf_valid <= pass;
         if (pass) begin
            ntf_peer <= dest;
            ntf_vec  <= vec;
         end
      end
   end

   a_r8_notify_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ntf_valid |-> $past(fire));

   a_r9_bad_dest_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !(dest < peer_count)) |=> !ntf_valid);
endmodule

// File: rtl/db_irq.sv
module db_irq
   import db_pkg::*;
#(
   parameter bit IRQ_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] mask_q,
   input  logic [DATA_W-1:0] stat_q,
   input  logic              msi_mode,
   input  logic              irq_pin_en,
   output logic              irq
);
   logic level;
   assign level = !msi_mode && irq_pin_en && (|(stat_q & mask_q));

   if (IRQ_FLOP) begin : g_flop
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= level;
      end
      assign irq = irq_q;

      a_r12_suppress: assert property (@(posedge clk) disable iff (!rst_n)
         (msi_mode || !irq_pin_en) |=> !irq);
   end else begin : g_comb
      assign irq = level;

      a_r12_suppress: assert property (@(posedge clk) disable iff (!rst_n)
         (msi_mode || !irq_pin_en) |-> !irq);
   end
endmodule

// File: rtl/peer_doorbell_regs.sv
module peer_doorbell_regs
   import db_pkg::*;
#(
   parameter int NUM_PEERS = 8,
   parameter int CNT_W     = 8,
   parameter bit IRQ_FLOP  = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   output logic                       req_ready,
   input  logic                       req_write,
   input  logic [WIN_AW-1:0]          req_addr,
   input  logic [DATA_W-1:0]          req_wdata,
   output logic                       rsp_valid,
   output logic [DATA_W-1:0]          rsp_rdata,
   input  logic [PEER_W-1:0]          own_id,
   input  logic [PEER_W-1:0]          peer_count,
   input  logic [NUM_PEERS*CNT_W-1:0] vec_cnt_tbl,
   input  logic                       msi_mode,
   input  logic                       irq_pin_en,
   input  logic                       local_event,
   output logic                       irq,
   output logic                       ntf_valid,
   output logic [PEER_W-1:0]          ntf_peer,
   output logic [VEC_W-1:0]           ntf_vec
);
   if (NUM_PEERS < 2 || NUM_PEERS > 4096) begin : g_bad_peers
      $error("NUM_PEERS must lie in 2..4096");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must lie in 1..16");
   end

   logic              acc;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] stat_q;
   logic              bell_fire;

   assign req_ready = 1'b1;
   assign acc       = req_valid;
   assign idx       = req_addr[WIN_AW-1:2];
   assign bell_fire = acc && req_write && idx == W_BELL;

   db_regfile u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc         (acc),
      .wr          (req_write),
      .idx         (idx),
      .wdata       (req_wdata),
      .own_id      (own_id),
      .msi_mode    (msi_mode),
      .local_event (local_event),
      .mask_q      (mask_q),
      .stat_q      (stat_q),
      .rsp_valid   (rsp_valid),
      .rsp_rdata   (rsp_rdata)
   );

   db_bell_check #(.NUM_PEERS(NUM_PEERS), .CNT_W(CNT_W)) u_bell (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire        (bell_fire),
      .dest        (req_wdata[31:16]),
      .vec         (req_wdata[7:0]),
      .peer_count  (peer_count),
      .vec_cnt_tbl (vec_cnt_tbl),
      .ntf_valid   (ntf_valid),
      .ntf_peer    (ntf_peer),
      .ntf_vec     (ntf_vec)
   );

   db_irq #(.IRQ_FLOP(IRQ_FLOP)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_q     (mask_q),
      .stat_q     (stat_q),
      .msi_mode   (msi_mode),
      .irq_pin_en (irq_pin_en),
      .irq        (irq)
   );

   a_r7_low_bits_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_write && req_addr[1:0] != 2'b00 && idx == W_POS)
      |=> (rsp_rdata == {16'h0000, $past(own_id)}));
endmodule

// File: tb/sim_peer_doorbell_regs.sv
`timescale 1ns/1ps
module sim_peer_doorbell_regs;
   localparam int NP = 8;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [7:0]    req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic          rsp_valid;
   logic [31:0]   rsp_rdata;
   logic [15:0]   own_id = 16'h0A5C;
   logic [15:0]   peer_count = 16'd6;
   logic [NP*CW-1:0] vec_cnt_tbl;
   logic          msi_mode = 1'b0;
   logic          irq_pin_en = 1'b1;
   logic          local_event = 1'b0;
   logic          irq;
   logic          ntf_valid;
   logic [15:0]   ntf_peer;
   logic [7:0]    ntf_vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [31:0] m_mask = '0;
   logic [31:0] m_stat = '0;

   always #2.5 clk = ~clk;

   peer_doorbell_regs #(.NUM_PEERS(NP), .CNT_W(CW)) u0 (.*);

   function automatic int tbl_cnt(input int p);
      return (p * 3) % 5;
   endfunction

   initial begin
      for (int i = 0; i < NP; i++) vec_cnt_tbl[i*CW +: CW] = CW'(tbl_cnt(i));
   end

   function automatic logic exp_irq();
      return !msi_mode && irq_pin_en && (|(m_stat & m_mask));
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      case (a[7:2])
         6'd0:    return m_mask;
         6'd1:    return m_stat;
         6'd2:    return {16'h0, own_id};
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic bell_ok(input logic [31:0] d);
      int dst = int'(d[31:16]);
      if (dst >= int'(peer_count) || dst >= NP) return 1'b0;
      return int'(d[7:0]) < tbl_cnt(dst);
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] d, input bit ev);
      logic [31:0] erd;
      logic        ebell;
      logic        is_bell;
      string       tag;
      erd     = exp_read(a);
      is_bell = wr && a[7:2] == 6'd3;
      ebell   = is_bell && bell_ok(d);
      req_valid   = 1'b1;
      req_write   = wr;
      req_addr    = a;
      req_wdata   = d;
      local_event = ev;
      @(negedge clk);
      req_valid   = 1'b0;
      local_event = 1'b0;
      if (wr && a[7:2] == 6'd0) m_mask = d;
      if (ev && !msi_mode) m_stat = 32'd1;
      else if (wr && a[7:2] == 6'd1) m_stat = d;
      else if (!wr && a[7:2] == 6'd1) m_stat = 32'd0;
      if (!wr) begin
         case (a[7:2])
            6'd0: tag = "R2";
            6'd1: tag = ev ? "R11" : "R4";
            6'd2: tag = "R5";
            default: tag = "R6";
         endcase
         if (a[1:0] != 2'b00) tag = {tag, "/R7"};
         chk(rsp_valid == 1'b1, {tag, " rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
         chk(rsp_rdata == erd, {tag, " rdata"}, rsp_rdata, erd);
      end
      if (is_bell) begin
         if (ebell) tag = "R8";
         else if (int'(d[31:16]) >= int'(peer_count) || int'(d[31:16]) >= NP) tag = "R9";
         else tag = "R10";
      end else tag = "R6";
      chk(ntf_valid == ebell, {tag, " ntf_valid"}, {31'b0, ntf_valid}, {31'b0, ebell});
      if (ebell) begin
         chk(ntf_peer == d[31:16], "R8 ntf_peer", {16'b0, ntf_peer}, {16'b0, d[31:16]});
         chk(ntf_vec == d[7:0], "R8 ntf_vec", {24'b0, ntf_vec}, {24'b0, d[7:0]});
      end
      tag = (msi_mode || !irq_pin_en) ? "R12" : (ev ? "R11" : "R3");
      chk(irq == exp_irq(), {tag, " irq"}, {31'b0, irq}, {31'b0, exp_irq()});
   endtask

   task automatic set_mode(input logic m, input logic p);
      msi_mode   = m;
      irq_pin_en = p;
      @(negedge clk);
      chk(irq == exp_irq(), (m || !p) ? "R12 mode irq" : "R3 mode irq", {31'b0, irq}, {31'b0, exp_irq()});
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(irq == 1'b0, "R1 irq", {31'b0, irq}, 32'd0);
      chk(ntf_valid == 1'b0, "R1 ntf_valid", {31'b0, ntf_valid}, 32'd0);
      access(1'b0, 8'h00, 32'h0, 1'b0);
      access(1'b0, 8'h04, 32'h0, 1'b0);
      // R2 / R3 / R4
      access(1'b1, 8'h00, 32'h0000_0004, 1'b0);
      access(1'b0, 8'h00, 32'h0, 1'b0);
      access(1'b1, 8'h04, 32'h0000_0005, 1'b0);
      access(1'b0, 8'h04, 32'h0, 1'b0);
      access(1'b0, 8'h04, 32'h0, 1'b0);
      // R5 / R7 / R6
      access(1'b1, 8'h08, 32'hFFFF_FFFF, 1'b0);
      access(1'b0, 8'h08, 32'h0, 1'b0);
      access(1'b0, 8'h0B, 32'h0, 1'b0);
      access(1'b1, 8'h03, 32'h0000_0001, 1'b0);
      access(1'b0, 8'h01, 32'h0, 1'b0);
      access(1'b0, 8'h0C, 32'h0, 1'b0);
      access(1'b1, 8'hF0, 32'hDEAD_BEEF, 1'b0);
      access(1'b0, 8'hFF, 32'h0, 1'b0);
      // R8 / R9 / R10 doorbells
      access(1'b1, 8'h0C, 32'h0001_AB02, 1'b0);
      access(1'b1, 8'h0E, 32'h0003_0003, 1'b0);
      access(1'b1, 8'h0C, 32'h0001_0003, 1'b0);
      access(1'b1, 8'h0C, 32'h0006_0000, 1'b0);
      access(1'b1, 8'h0C, 32'h0009_0000, 1'b0);
      access(1'b1, 8'h0C, 32'h0000_0000, 1'b0);
      // R11 event, concurrent read, MSI-mode ignore
      access(1'b1, 8'h04, 32'h0000_0005, 1'b0);
      access(1'b0, 8'h04, 32'h0, 1'b1);
      access(1'b0, 8'h04, 32'h0, 1'b0);
      access(1'b1, 8'h00, 32'h0000_0001, 1'b0);
      access(1'b1, 8'h10, 32'h0, 1'b1);
      set_mode(1'b1, 1'b1);
      access(1'b0, 8'h04, 32'h0, 1'b0);
      access(1'b1, 8'h10, 32'h0, 1'b1);
      access(1'b0, 8'h04, 32'h0, 1'b0);
      // R12 suppression with status & mask set
      access(1'b1, 8'h04, 32'h0000_0001, 1'b0);
      set_mode(1'b0, 1'b0);
      set_mode(1'b0, 1'b1);
      // random phase
      for (int it = 0; it < 800; it++) begin
         int op;
         logic [31:0] v;
         if (it % 200 == 0) begin
            case (it / 200)
               0: set_mode(1'b0, 1'b1);
               1: set_mode(1'b1, 1'b1);
               2: set_mode(1'b0, 1'b0);
               default: set_mode(1'b0, 1'b1);
            endcase
         end
         op = int'($urandom % 8);
         v  = ($urandom % 2 == 0) ? ($urandom & 32'hF) : $urandom;
         case (op)
            0, 1: access(1'b1, {6'd0, 2'($urandom)}, v, 1'b0);
            2:    access(1'b1, {6'd1, 2'($urandom)}, v, $urandom % 6 == 0);
            3:    access(1'b0, {6'd1, 2'($urandom)}, 32'h0, $urandom % 6 == 0);
            4:    access(1'b0, 8'($urandom), 32'h0, 1'b0);
            5:    access(1'b1, 8'h0C, {16'($urandom % 10), 8'($urandom), 8'($urandom % 6)}, 1'b0);
            6:    access(1'b1, 8'h40, v, 1'b1);
            default: access(1'b1, 8'($urandom | 32'h10), v, 1'b0);
         endcase
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule